// File: doc/BRIEF.md
# Background Integer Divider with Decode-Stage Hazard Check

This block does the integer division for a small in-order core. It covers signed and unsigned quotient and remainder. A division starts when decode accepts it. After that the divider works on its own, one quotient bit per clock, while later instructions keep issuing. Decode does not freeze the pipeline for the whole operation. It compares each new instruction against the register the divider will write, and it raises a stall only when that instruction depends on the pending result.

The comparison uses only the register fields that the instruction's opcode actually reads or writes. Register x0 never counts as a dependency. An instruction that writes the pending destination is held back, and so is a second division. When the quotient or remainder is ready, the divider takes the single register-file write port for one cycle. An execute-stage write that arrives in that same cycle is told to hold and retry one cycle later.

Top module: `bgdiv_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `div_busy`, `id_stall`, `rf_we` and `ex_hold` are low.
- R2: A word with opcode bits [6:0] = 0110011 and bits [31:25] = 0000001 is a division when funct3 (bits [14:12]) has bit 2 set. The funct3 values are 100 for signed quotient, 101 for unsigned quotient, 110 for signed remainder and 111 for unsigned remainder. A signed result divides the magnitudes, then negates the quotient when the operand signs differ and gives the remainder the sign of the dividend.
- R3: Division by zero gives a quotient of all ones and a remainder equal to the dividend, in both signed and unsigned forms.
- R4: A signed division of the most negative value by -1 gives that same most negative value as the quotient and 0 as the remainder.
- R5: `div_busy` rises on the cycle after the division is accepted and stays high for exactly XLEN+1 cycles. While it is high, `div_pend_rd` holds the accepted instruction's rd field (bits [11:7]).
- R6: The result is presented on `rf_we`/`rf_waddr`/`rf_wdata` in the last busy cycle, which is the XLEN+1th cycle after acceptance. It is written only when the destination is not x0.
- R7: While busy with a nonzero pending destination, `id_stall` is raised for a valid instruction that reads that register. rs1 is bits [19:15] and is read by opcodes 0110011, 0010011, 0000011, 1100111, 0100011 and 1100011. rs2 is bits [24:20] and is read by 0110011, 0100011 and 1100011.
- R8: No stall is raised when the matching field is not one that the opcode uses, when no field matches, or when the pending destination is x0.
- R9: While busy, `id_stall` is raised for a valid instruction whose rd field equals the nonzero pending destination and that writes rd. The opcodes that write rd are 0110011, 0010011, 0000011, 1100111, 1101111, 0110111 and 0010111.
- R10: While busy, a second valid division raises `id_stall` and is not accepted.
- R11: An execute-stage write passes straight to the register-file port when the divider is not writing. In the cycle the divider writes, `ex_hold` is raised and the divider's write takes the port.
- R12: `id_stall` is never raised while the divider is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_valid | input | 1 | Decode holds a valid instruction |
| id_instr | input | 32 | Instruction word in decode |
| id_op_a | input | XLEN | Dividend value for a division in decode |
| id_op_b | input | XLEN | Divisor value for a division in decode |
| id_stall | output | 1 | Stall request to pipeline control |
| ex_wr_en | input | 1 | Execute-stage register write request |
| ex_wr_addr | input | 5 | Execute-stage write address |
| ex_wr_data | input | XLEN | Execute-stage write data |
| ex_hold | output | 1 | Execute write deferred this cycle; retry next cycle |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 5 | Register-file write address |
| rf_wdata | output | XLEN | Register-file write data |
| div_busy | output | 1 | Division in progress |
| div_pend_rd | output | 5 | Destination of the pending division |

## Verification
The bound checker watches every cycle for the following. The busy window must have its fixed length, and the pending destination must stay stable inside it. A stall must never appear while the divider is idle. A second division while busy must always be stalled. The divider's write must land only in the last busy cycle and never to x0. Port arbitration must either pass the execute write through or hold it. The checker cannot tell whether quotients and remainders are numerically right, including the zero-divisor and overflow cases. It also cannot tell whether a given opcode's field choice is right, whether a read, write or unused field should stall. The bench's vector table and its directed decode probes during a live division show those.

// File: rtl/bgdiv_pkg.sv
package bgdiv_pkg;

  localparam int unsigned REG_AW = 5;

  typedef enum logic [1:0] {
    DV_IDLE = 2'd0,
    DV_RUN  = 2'd1,
    DV_DONE = 2'd2
  } dv_state_e;

  typedef struct packed {
    logic              uses_rs1;
    logic              uses_rs2;
    logic              writes_rd;
    logic              is_div;
    logic              div_signed;
    logic              div_rem;
    logic [REG_AW-1:0] rs1;
    logic [REG_AW-1:0] rs2;
    logic [REG_AW-1:0] rd;
  } dec_info_t;

  // Field usage per base opcode; only these fields may create a hazard.
  function automatic dec_info_t decode_word(input logic [31:0] w);
    dec_info_t d;
    d            = '0;
    d.rs1        = w[19:15];
    d.rs2        = w[24:20];
    d.rd         = w[11:7];
    d.div_signed = ~w[12];
    d.div_rem    = w[13];
    unique case (w[6:0])
      7'b0110011: begin
        d.uses_rs1  = 1'b1;
        d.uses_rs2  = 1'b1;
        d.writes_rd = 1'b1;
        d.is_div    = (w[31:25] == 7'b0000001) && w[14];
      end
      7'b0010011, 7'b0000011, 7'b1100111: begin
        d.uses_rs1  = 1'b1;
        d.writes_rd = 1'b1;
      end
      7'b0100011, 7'b1100011: begin
        d.uses_rs1 = 1'b1;
        d.uses_rs2 = 1'b1;
      end
      7'b1101111, 7'b0110111, 7'b0010111: begin
        d.writes_rd = 1'b1;
      end
      default: ;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/bgdiv_hazard.sv
module bgdiv_hazard
  import bgdiv_pkg::*;
(
  input  logic              id_valid,
  input  logic [31:0]       id_instr,
  input  logic              div_busy,
  input  logic [REG_AW-1:0] pend_rd,
  output logic              stall,
  output logic              raw_hit,
  output logic              waw_hit,
  output logic              struct_hit,
  output logic              is_div,
  output logic              div_signed,
  output logic              div_rem,
  output logic [REG_AW-1:0] dst_rd
);

  dec_info_t dec;
  logic      pend_live;

  assign dec       = decode_word(id_instr);
  assign pend_live = div_busy && (pend_rd != '0);

  assign raw_hit    = pend_live &&
                      ((dec.uses_rs1 && (dec.rs1 == pend_rd)) ||
                       (dec.uses_rs2 && (dec.rs2 == pend_rd)));
  assign waw_hit    = pend_live && dec.writes_rd && (dec.rd == pend_rd);
  assign struct_hit = div_busy && dec.is_div;
  assign stall      = id_valid && (raw_hit || waw_hit || struct_hit);

  assign is_div     = dec.is_div;
  assign div_signed = dec.div_signed;
  assign div_rem    = dec.div_rem;
  assign dst_rd     = dec.rd;

endmodule

// File: rtl/bgdiv_core.sv
module bgdiv_core
  import bgdiv_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_signed,
  input  logic              op_rem,
  input  logic [XLEN-1:0]   op_a,
  input  logic [XLEN-1:0]   op_b,
  input  logic [REG_AW-1:0] dst,
  output logic              busy,
  output logic              done,
  output logic [REG_AW-1:0] pend_rd,
  output logic [XLEN-1:0]   result
);

  localparam int CW = $clog2(XLEN + 1);
  localparam logic [CW-1:0] LAST_STEP = CW'(XLEN - 1);

  function automatic logic [XLEN-1:0] twos(input logic [XLEN-1:0] v);
    return ~v + 1'b1;
  endfunction

  function automatic logic [XLEN-1:0] mag(input logic [XLEN-1:0] v, input logic sgn);
    return (sgn && v[XLEN-1]) ? twos(v) : v;
  endfunction

  // One restoring step: {quotient bit, new partial remainder}.
  function automatic logic [XLEN:0] trial_step(input logic [XLEN-1:0] part,
                                               input logic            inbit,
                                               input logic [XLEN-1:0] dv);
    logic [XLEN:0] t;
    t = {part, inbit};
    if (t >= {1'b0, dv}) return {1'b1, XLEN'(t - {1'b0, dv})};
    return {1'b0, t[XLEN-1:0]};
  endfunction

  function automatic logic [XLEN-1:0] finish(input logic [XLEN-1:0] q,
                                             input logic [XLEN-1:0] r,
                                             input logic            nq,
                                             input logic            nr,
                                             input logic            sel_rem);
    if (sel_rem) return nr ? twos(r) : r;
    return nq ? twos(q) : q;
  endfunction

  dv_state_e         state;
  logic [CW-1:0]     cnt;
  logic [XLEN-1:0]   dvd;
  logic [XLEN-1:0]   dvs;
  logic [XLEN-1:0]   part;
  logic [XLEN-1:0]   quo;
  logic              neg_q;
  logic              neg_r;
  logic              want_rem;
  logic [REG_AW-1:0] rd_q;

  logic [XLEN:0]     step_w;
  logic              step_bit;
  logic [XLEN-1:0]   step_part;

  assign step_w    = trial_step(part, dvd[XLEN-1], dvs);
  assign step_bit  = step_w[XLEN];
  assign step_part = step_w[XLEN-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= DV_IDLE;
      cnt      <= '0;
      dvd      <= '0;
      dvs      <= '0;
      part     <= '0;
      quo      <= '0;
      neg_q    <= 1'b0;
      neg_r    <= 1'b0;
      want_rem <= 1'b0;
      rd_q     <= '0;
    end else begin
      unique case (state)
        DV_IDLE: begin
          if (start) begin
            dvd      <= mag(op_a, op_signed);
            dvs      <= mag(op_b, op_signed);
            part     <= '0;
            quo      <= '0;
            cnt      <= '0;
            neg_q    <= op_signed && (op_a[XLEN-1] ^ op_b[XLEN-1]) && (|op_b);
            neg_r    <= op_signed && op_a[XLEN-1];
            want_rem <= op_rem;
            rd_q     <= dst;
            state    <= DV_RUN;
          end
        end
        DV_RUN: begin
          part <= step_part;
          quo  <= {quo[XLEN-2:0], step_bit};
          dvd  <= {dvd[XLEN-2:0], 1'b0};
          cnt  <= cnt + 1'b1;
          if (cnt == LAST_STEP) state <= DV_DONE;
        end
        default: state <= DV_IDLE;
      endcase
    end
  end

  assign busy    = (state != DV_IDLE);
  assign done    = (state == DV_DONE);
  assign pend_rd = rd_q;
  assign result  = finish(quo, part, neg_q, neg_r, want_rem);

endmodule

// File: rtl/bgdiv_wrport.sv
module bgdiv_wrport
  import bgdiv_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              div_done,
  input  logic [REG_AW-1:0] div_rd,
  input  logic [XLEN-1:0]   div_res,
  input  logic              ex_wr_en,
  input  logic [REG_AW-1:0] ex_wr_addr,
  input  logic [XLEN-1:0]   ex_wr_data,
  output logic              div_take,
  output logic              ex_hold,
  output logic              rf_we,
  output logic [REG_AW-1:0] rf_waddr,
  output logic [XLEN-1:0]   rf_wdata
);

  assign div_take = div_done && (div_rd != '0);
  assign ex_hold  = div_take && ex_wr_en;
  assign rf_we    = div_take || ex_wr_en;

  always_comb begin
    if (div_take) begin
      rf_waddr = div_rd;
      rf_wdata = div_res;
    end else begin
      rf_waddr = ex_wr_addr;
      rf_wdata = ex_wr_data;
    end
  end

endmodule

// File: rtl/bgdiv_unit.sv
module bgdiv_unit
  import bgdiv_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_valid,
  input  logic [31:0]       id_instr,
  input  logic [XLEN-1:0]   id_op_a,
  input  logic [XLEN-1:0]   id_op_b,
  output logic              id_stall,
  input  logic              ex_wr_en,
  input  logic [REG_AW-1:0] ex_wr_addr,
  input  logic [XLEN-1:0]   ex_wr_data,
  output logic              ex_hold,
  output logic              rf_we,
  output logic [REG_AW-1:0] rf_waddr,
  output logic [XLEN-1:0]   rf_wdata,
  output logic              div_busy,
  output logic [REG_AW-1:0] div_pend_rd
);

  logic              raw_hit;
  logic              waw_hit;
  logic              struct_hit;
  logic              dec_is_div;
  logic              dec_signed;
  logic              dec_rem;
  logic [REG_AW-1:0] dec_rd;
  logic              div_start;
  logic              div_done;
  logic              div_take;
  logic [XLEN-1:0]   div_res;

  bgdiv_hazard u_hazard (
    .id_valid   (id_valid),
    .id_instr   (id_instr),
    .div_busy   (div_busy),
    .pend_rd    (div_pend_rd),
    .stall      (id_stall),
    .raw_hit    (raw_hit),
    .waw_hit    (waw_hit),
    .struct_hit (struct_hit),
    .is_div     (dec_is_div),
    .div_signed (dec_signed),
    .div_rem    (dec_rem),
    .dst_rd     (dec_rd)
  );

  assign div_start = id_valid && dec_is_div && !id_stall;

  bgdiv_core #(.XLEN(XLEN)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (div_start),
    .op_signed (dec_signed),
    .op_rem    (dec_rem),
    .op_a      (id_op_a),
    .op_b      (id_op_b),
    .dst       (dec_rd),
    .busy      (div_busy),
    .done      (div_done),
    .pend_rd   (div_pend_rd),
    .result    (div_res)
  );

  bgdiv_wrport #(.XLEN(XLEN)) u_wrport (
    .div_done   (div_done),
    .div_rd     (div_pend_rd),
    .div_res    (div_res),
    .ex_wr_en   (ex_wr_en),
    .ex_wr_addr (ex_wr_addr),
    .ex_wr_data (ex_wr_data),
    .div_take   (div_take),
    .ex_hold    (ex_hold),
    .rf_we      (rf_we),
    .rf_waddr   (rf_waddr),
    .rf_wdata   (rf_wdata)
  );

endmodule

// File: rtl/bgdiv_unit_chk.sv
module bgdiv_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            id_valid,
  input logic [31:0]     id_instr,
  input logic            id_stall,
  input logic            ex_wr_en,
  input logic [4:0]      ex_wr_addr,
  input logic [XLEN-1:0] ex_wr_data,
  input logic            ex_hold,
  input logic            rf_we,
  input logic [4:0]      rf_waddr,
  input logic [XLEN-1:0] rf_wdata,
  input logic            div_busy,
  input logic [4:0]      div_pend_rd,
  input logic            div_start,
  input logic            div_take,
  input logic            is_div
);

  localparam int BW = $clog2(XLEN + 2) + 1;
  localparam logic [BW-1:0] BUSY_LEN = BW'(XLEN + 1);

  logic [BW-1:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt <= '0;
    else        bcnt <= div_busy ? bcnt + 1'b1 : '0;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !div_busy && !rf_we && !ex_hold);

  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(div_busy) |-> bcnt == BUSY_LEN);

  p_busy_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> bcnt < BUSY_LEN);

  p_start_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    div_start |=> div_busy && (div_pend_rd == $past(id_instr[11:7])));

  p_pend_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy && $past(div_busy) |-> $stable(div_pend_rd));

  p_write_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    div_take |=> !div_busy);

  p_write_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    div_take |-> div_busy && bcnt == BUSY_LEN - 1'b1);

  p_no_x0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    div_take |-> rf_we && (rf_waddr != 5'd0) && (rf_waddr == div_pend_rd));

  p_second_div_r10: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid && is_div && div_busy |-> id_stall && !div_start);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ex_hold |-> ex_wr_en && div_take);

  p_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ex_wr_en && !div_take |-> rf_we && !ex_hold &&
                               (rf_waddr == ex_wr_addr) && (rf_wdata == ex_wr_data));

  p_idle_nostall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    id_stall |-> div_busy);

endmodule

bind bgdiv_unit bgdiv_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .id_valid    (id_valid),
  .id_instr    (id_instr),
  .id_stall    (id_stall),
  .ex_wr_en    (ex_wr_en),
  .ex_wr_addr  (ex_wr_addr),
  .ex_wr_data  (ex_wr_data),
  .ex_hold     (ex_hold),
  .rf_we       (rf_we),
  .rf_waddr    (rf_waddr),
  .rf_wdata    (rf_wdata),
  .div_busy    (div_busy),
  .div_pend_rd (div_pend_rd),
  .div_start   (div_start),
  .div_take    (div_take),
  .is_div      (dec_is_div)
);

// File: tb/bgdiv_unit_test.sv
module bgdiv_unit_test;

  localparam int XLEN = 32;
  localparam int CLK_NS = 20;
  localparam int NVEC = 18;
  localparam int LAT = XLEN + 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            id_valid = 1'b0;
  logic [31:0]     id_instr = '0;
  logic [XLEN-1:0] id_op_a = '0;
  logic [XLEN-1:0] id_op_b = '0;
  logic            id_stall;
  logic            ex_wr_en = 1'b0;
  logic [4:0]      ex_wr_addr = '0;
  logic [XLEN-1:0] ex_wr_data = '0;
  logic            ex_hold;
  logic            rf_we;
  logic [4:0]      rf_waddr;
  logic [XLEN-1:0] rf_wdata;
  logic            div_busy;
  logic [4:0]      div_pend_rd;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  bgdiv_unit #(.XLEN(XLEN)) uut (.*);

  // {funct3, dividend, divisor, expected}
  localparam logic [98:0] VEC [0:NVEC-1] = '{
    {3'b101, 32'd100,       32'd7,         32'd14},
    {3'b111, 32'd100,       32'd7,         32'd2},
    {3'b100, 32'hFFFFFF9C,  32'd7,         32'hFFFFFFF2},
    {3'b110, 32'hFFFFFF9C,  32'd7,         32'hFFFFFFFE},
    {3'b100, 32'd100,       32'hFFFFFFF9,  32'hFFFFFFF2},
    {3'b110, 32'd100,       32'hFFFFFFF9,  32'd2},
    {3'b100, 32'hFFFFFF9C,  32'hFFFFFFF9,  32'd14},
    {3'b110, 32'hFFFFFF9C,  32'hFFFFFFF9,  32'hFFFFFFFE},
    {3'b101, 32'hFFFFFFFF,  32'd1,         32'hFFFFFFFF},
    {3'b111, 32'hFFFFFFFF,  32'd1,         32'd0},
    {3'b101, 32'd5,         32'd0,         32'hFFFFFFFF},
    {3'b111, 32'd5,         32'd0,         32'd5},
    {3'b100, 32'hFFFFFFFB,  32'd0,         32'hFFFFFFFF},
    {3'b110, 32'hFFFFFFFB,  32'd0,         32'hFFFFFFFB},
    {3'b100, 32'h80000000,  32'hFFFFFFFF,  32'h80000000},
    {3'b110, 32'h80000000,  32'hFFFFFFFF,  32'd0},
    {3'b101, 32'h80000000,  32'hFFFFFFFF,  32'd0},
    {3'b111, 32'h80000000,  32'hFFFFFFFF,  32'h80000000}
  };

  function automatic logic [31:0] enc(input logic [6:0] f7, input logic [4:0] rs2,
                                      input logic [4:0] rs1, input logic [2:0] f3,
                                      input logic [4:0] rd, input logic [6:0] opc);
    return {f7, rs2, rs1, f3, rd, opc};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue_div(input logic [2:0] f3, input logic [4:0] rd,
                           input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    id_valid = 1'b1;
    id_instr = enc(7'b0000001, 5'd2, 5'd1, f3, rd, 7'b0110011);
    id_op_a  = a;
    id_op_b  = b;
    @(negedge clk);
    id_valid = 1'b0;
    id_instr = '0;
  endtask

  // Returns the cycle of the divider write and the number of busy cycles.
  task automatic run_div(input logic [2:0] f3, input logic [4:0] rd,
                         input logic [31:0] a, input logic [31:0] b,
                         output int wr_at, output int busy_n, output logic [31:0] got);
    issue_div(f3, rd, a, b);
    wr_at = -1; busy_n = 0; got = '0;
    #1;
    for (int n = 1; n <= LAT + 6; n++) begin
      if (div_busy) busy_n++;
      if (rf_we && rf_waddr == rd && wr_at < 0) begin
        wr_at = n;
        got   = rf_wdata;
      end
      @(negedge clk);
      #1;
    end
  endtask

  task automatic probe(input logic [31:0] w, input bit exp_stall, input string req,
                       input string what);
    @(negedge clk);
    id_valid = 1'b1;
    id_instr = w;
    #1;
    check(id_stall == exp_stall, req, what, 32'(id_stall), 32'(exp_stall));
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int wr_at, busy_n, wcount;
    logic [31:0] got;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(!div_busy && !id_stall && !rf_we && !ex_hold, "R1", "outputs in reset",
          {28'd0, div_busy, id_stall, rf_we, ex_hold}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!div_busy && !rf_we && !ex_hold, "R1", "outputs after reset",
          {29'd0, div_busy, rf_we, ex_hold}, 32'd0);

    // R2/R3/R4/R5/R6: vector table
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = (i >= 10 && i <= 13) ? "R3" : ((i >= 14 && i <= 15) ? "R4" : "R2");
      run_div(VEC[i][98:96], 5'd3 + 5'(i), VEC[i][95:64], VEC[i][63:32], wr_at, busy_n, got);
      check(got === VEC[i][31:0], tag, $sformatf("vector %0d result", i), got, VEC[i][31:0]);
      check(wr_at == LAT, "R6", $sformatf("vector %0d write cycle", i), 32'(wr_at), 32'(LAT));
      check(busy_n == LAT, "R5", $sformatf("vector %0d busy length", i), 32'(busy_n), 32'(LAT));
    end

    // R5/R7/R8/R9/R10: decode probes during a live division into x5
    issue_div(3'b101, 5'd5, 32'd1000, 32'd3);
    #1;
    check(div_busy && div_pend_rd == 5'd5, "R5", "pending rd visible",
          {26'd0, div_busy, div_pend_rd}, {26'd0, 1'b1, 5'd5});
    probe(enc(7'd0, 5'd1, 5'd5, 3'b000, 5'd6, 7'b0110011), 1'b1, "R7", "R-type rs1 match");
    probe(enc(7'd0, 5'd5, 5'd1, 3'b000, 5'd6, 7'b0110011), 1'b1, "R7", "R-type rs2 match");
    probe(enc(7'd0, 5'd5, 5'd1, 3'b010, 5'd0, 7'b0100011), 1'b1, "R7", "store rs2 match");
    probe(enc(7'd0, 5'd2, 5'd5, 3'b000, 5'd4, 7'b1100011), 1'b1, "R7", "branch rs1 match");
    probe(enc(7'd0, 5'd5, 5'd1, 3'b000, 5'd6, 7'b0010011), 1'b0, "R8", "imm-op rs2 field unused");
    probe(enc(7'd0, 5'd0, 5'd5, 3'b000, 5'd6, 7'b0110111), 1'b0, "R8", "upper-imm rs1 field unused");
    probe(enc(7'd0, 5'd0, 5'd5, 3'b000, 5'd6, 7'b1101111), 1'b0, "R8", "jump rs1 field unused");
    probe(enc(7'd0, 5'd2, 5'd1, 3'b010, 5'd5, 7'b0100011), 1'b0, "R8", "store rd field unused");
    probe(enc(7'd0, 5'd2, 5'd1, 3'b000, 5'd6, 7'b0110011), 1'b0, "R8", "no field match");
    probe(enc(7'd0, 5'd0, 5'd1, 3'b000, 5'd5, 7'b0010011), 1'b1, "R9", "write-after-write");
    probe(enc(7'b0000001, 5'd2, 5'd1, 3'b101, 5'd7, 7'b0110011), 1'b1, "R10", "second division");
    @(negedge clk);
    id_valid = 1'b0;
    #1;
    check(div_pend_rd == 5'd5, "R10", "second division not accepted", 32'(div_pend_rd), 32'd5);
    while (div_busy) @(negedge clk);
    probe(enc(7'd0, 5'd1, 5'd5, 3'b000, 5'd6, 7'b0110011), 1'b0, "R12", "reader after completion");
    probe(enc(7'b0000001, 5'd2, 5'd1, 3'b101, 5'd8, 7'b0110011), 1'b0, "R12", "division while idle");
    id_valid = 1'b0;
    @(negedge clk);
    while (div_busy) @(negedge clk);

    // R8/R6: division into x0 produces no hazard and no write
    issue_div(3'b101, 5'd0, 32'd9, 32'd3);
    probe(enc(7'd0, 5'd0, 5'd0, 3'b000, 5'd6, 7'b0110011), 1'b0, "R8", "pending x0 reader");
    id_valid = 1'b0;
    wcount = 0;
    for (int n = 0; n < LAT + 3; n++) begin
      @(negedge clk);
      #1;
      if (rf_we) wcount++;
    end
    check(wcount == 0, "R6", "no write for x0 destination", 32'(wcount), 32'd0);

    // R11: pass-through while idle
    @(negedge clk);
    ex_wr_en = 1'b1; ex_wr_addr = 5'd9; ex_wr_data = 32'h0000ABCD;
    #1;
    check(rf_we && rf_waddr == 5'd9 && rf_wdata == 32'h0000ABCD && !ex_hold, "R11",
          "execute write passes", rf_wdata, 32'h0000ABCD);
    @(negedge clk);
    ex_wr_en = 1'b0;

    // R11: collision with divider write
    issue_div(3'b101, 5'd12, 32'd50, 32'd5);
    repeat (LAT - 1) @(negedge clk);
    ex_wr_en = 1'b1; ex_wr_addr = 5'd9; ex_wr_data = 32'h0000ABCD;
    #1;
    check(rf_we && rf_waddr == 5'd12 && rf_wdata == 32'd10, "R11", "divider wins port",
          {rf_waddr, rf_wdata[26:0]}, {5'd12, 27'd10});
    check(ex_hold == 1'b1, "R11", "execute held", 32'(ex_hold), 32'd1);
    @(negedge clk);
    #1;
    check(rf_we && rf_waddr == 5'd9 && rf_wdata == 32'h0000ABCD && !ex_hold, "R11",
          "held write lands next cycle", rf_wdata, 32'h0000ABCD);
    ex_wr_en = 1'b0;
    @(negedge clk);
    #1;
    check(!div_busy && !id_stall, "R12", "idle after collision",
          {30'd0, div_busy, id_stall}, 32'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule